// File: doc/BRIEF.md
# Uploaded Command Capture Buffer

This block sits behind a flash command decoder and keeps a copy of every command whose slot is flagged for upload, so that firmware can later emulate it. On each command strobe the decoder presents the opcode and the slot's upload flag. When the flag is set, the opcode enters a command queue, and the rest of that command is captured too: the address goes to an address queue when the command has an address phase, and payload bytes go to a circular byte buffer. When the flag is clear, the block ignores the command and everything that follows it, up to the next command strobe.

The payload buffer keeps only the newest bytes. A host that sends more than the buffer holds wraps around and overwrites the oldest bytes. The buffer reports both how many bytes it holds and the index of the oldest byte still present. On the register side, firmware can read both queue counts and pop one entry at a time from either queue. A pop of an empty queue returns an unavailable pulse instead of data. Any byte of the payload buffer can be read by index.

The decoder inputs are valid-only streams: each strobe counts as accepted in the cycle it is high, and there is no ready signal. This is because the serial host cannot be stalled. When a queue is full, a push is dropped and a sticky overflow flag is set.

Top module: `upload_capture`

## Requirements
- R1: After reset, both queue counts, the payload occupancy and the payload start offset are 0, and both overflow flags are 0.
- R2: An opcode is pushed only when `cmd_valid` is high together with `cmd_upload`. A command strobe with `cmd_upload` low pushes nothing. The address and payload strobes that follow it, up to the next command strobe, change neither queue count nor the payload occupancy.
- R3: The command queue returns opcodes in arrival order. `cmd_count` gives the number held. The head is visible on `cmd_head`, and a `cmd_pop` removes it on the clock edge.
- R4: An address strobe during an uploaded command pushes one 32-bit entry. With `addr_4b` high the entry is `addr_in` unchanged. With `addr_4b` low, bits 31:24 are forced to zero.
- R5: Payload bytes of an uploaded command are written at indices 0, 1, 2 and so on. `pay_occ` counts them, and `pay_rd_data` returns the byte at `pay_rd_idx`.
- R6: After 256 bytes the write index wraps to 0 and overwrites the oldest byte. `pay_occ` saturates at 256, and `pay_start` then equals the next write index (with 260 bytes sent: `pay_start` = 4).
- R7: Each uploaded command strobe resets the payload occupancy, the start offset and the write index to 0.
- R8: A pop of an empty queue raises that queue's unavailable output in the same cycle, and the count stays 0.
- R9: Each queue holds 8 entries. A push into a full queue is dropped, the count stays at 8, and the queue's overflow flag sets and stays set until reset.
- R10: A push and a pop of the same non-empty, non-full queue in one cycle leave its count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Start of a decoded command |
| cmd_upload | input | 1 | Upload flag of the matched slot |
| cmd_opcode | input | 8 | Opcode of the command |
| addr_valid | input | 1 | Address phase complete |
| addr_in | input | 32 | Decoded address |
| addr_4b | input | 1 | 1 = 4-byte addressing, 0 = 3-byte |
| pay_valid | input | 1 | Payload byte strobe |
| pay_byte | input | 8 | Payload byte |
| cmd_pop | input | 1 | Pop command queue head |
| cmd_head | output | 8 | Command queue head |
| cmd_count | output | 4 | Command queue entries |
| cmd_unavail | output | 1 | Pop of empty command queue |
| cmd_ovf | output | 1 | Sticky command queue overflow |
| addr_pop | input | 1 | Pop address queue head |
| addr_head | output | 32 | Address queue head |
| addr_count | output | 4 | Address queue entries |
| addr_unavail | output | 1 | Pop of empty address queue |
| addr_ovf | output | 1 | Sticky address queue overflow |
| pay_rd_idx | input | 8 | Payload read index |
| pay_rd_data | output | 8 | Payload byte at index |
| pay_occ | output | 9 | Payload bytes held, at most 256 |
| pay_start | output | 8 | Index of oldest payload byte |

## Verification
The bench builds the block with its default parameters: 8-entry queues and a 256-byte payload buffer. The queue depth is small, so a short burst of nine commands reaches the full and overflow paths. The payload wrap needs only 260 bytes, which lets the bench check saturation and the moved start offset directly. It also reads back the overwritten and the surviving bytes by index.

// File: rtl/ucb_pkg.sv
package ucb_pkg;
  localparam int OP_W   = 8;
  localparam int ADDR_W = 32;

  function automatic logic [ADDR_W-1:0] form_addr(input logic [ADDR_W-1:0] a, input logic four_b);
    return four_b ? a : {8'h00, a[23:0]};
  endfunction
endpackage

// File: rtl/ucb_fifo.sv
module ucb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic [W-1:0]         din,
  input  logic                 pop,
  output logic [W-1:0]         dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                 unavail,
  output logic                 ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign unavail = pop && empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n) count <= CW'(DEPTH));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (count == CW'(DEPTH)) && ovf);
  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count == '0));
  p_push_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(count));
endmodule

// File: rtl/ucb_payload_ring.sv
module ucb_payload_ring #(
  parameter int BYTES = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr,
  input  logic [7:0]                  wdata,
  input  logic [$clog2(BYTES)-1:0]    rd_idx,
  output logic [7:0]                  rd_data,
  output logic [$clog2(BYTES+1)-1:0]  occ,
  output logic [$clog2(BYTES)-1:0]    start
);
  localparam int AW = $clog2(BYTES);
  localparam int OW = $clog2(BYTES+1);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] wptr;
  logic          sat;

  assign sat     = (occ == OW'(BYTES));
  assign start   = sat ? wptr : '0;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr && !clear) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      occ  <= '0;
    end else if (clear) begin
      wptr <= '0;
      occ  <= '0;
    end else if (wr) begin
      wptr <= (wptr == AW'(BYTES-1)) ? '0 : wptr + 1'b1;
      if (!sat) occ <= occ + 1'b1;
    end
  end

  p_occ_sat_r6: assert property (@(posedge clk) disable iff (!rst_n) occ <= OW'(BYTES));
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (occ == '0) && (start == '0));
  p_occ_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clear && !sat) |=> (occ == $past(occ) + 1'b1));
  p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clear && sat) |=> (occ == OW'(BYTES)));
endmodule

// File: rtl/upload_capture.sv
module upload_capture #(
  parameter int QDEPTH    = 8,
  parameter int PAY_BYTES = 256
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cmd_valid,
  input  logic                              cmd_upload,
  input  logic [7:0]                        cmd_opcode,
  input  logic                              addr_valid,
  input  logic [31:0]                       addr_in,
  input  logic                              addr_4b,
  input  logic                              pay_valid,
  input  logic [7:0]                        pay_byte,
  input  logic                              cmd_pop,
  output logic [7:0]                        cmd_head,
  output logic [$clog2(QDEPTH+1)-1:0]       cmd_count,
  output logic                              cmd_unavail,
  output logic                              cmd_ovf,
  input  logic                              addr_pop,
  output logic [31:0]                       addr_head,
  output logic [$clog2(QDEPTH+1)-1:0]       addr_count,
  output logic                              addr_unavail,
  output logic                              addr_ovf,
  input  logic [$clog2(PAY_BYTES)-1:0]      pay_rd_idx,
  output logic [7:0]                        pay_rd_data,
  output logic [$clog2(PAY_BYTES+1)-1:0]    pay_occ,
  output logic [$clog2(PAY_BYTES)-1:0]      pay_start
);
  import ucb_pkg::*;

  logic active;
  logic op_push, ad_push, pb_wr, pb_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (cmd_valid) active <= cmd_upload;
  end

  assign op_push  = cmd_valid && cmd_upload;
  assign pb_clear = op_push;
  assign ad_push  = active && !cmd_valid && addr_valid;
  assign pb_wr    = active && !cmd_valid && pay_valid;

  ucb_fifo #(.W(OP_W), .DEPTH(QDEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(op_push), .din(cmd_opcode), .pop(cmd_pop),
    .dout(cmd_head), .count(cmd_count), .unavail(cmd_unavail), .ovf(cmd_ovf));

  ucb_fifo #(.W(ADDR_W), .DEPTH(QDEPTH)) u_addrq (
    .clk(clk), .rst_n(rst_n), .push(ad_push), .din(form_addr(addr_in, addr_4b)), .pop(addr_pop),
    .dout(addr_head), .count(addr_count), .unavail(addr_unavail), .ovf(addr_ovf));

  ucb_payload_ring #(.BYTES(PAY_BYTES)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(pb_clear), .wr(pb_wr), .wdata(pay_byte),
    .rd_idx(pay_rd_idx), .rd_data(pay_rd_data), .occ(pay_occ), .start(pay_start));

  p_skip_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_upload && !cmd_pop) |=> $stable(cmd_count));
  p_skip_pay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cmd_valid) |=> $stable(pay_occ));
endmodule

// File: tb/sim_upload_capture.sv
module sim_upload_capture;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic cmd_valid = 0, cmd_upload = 0, addr_valid = 0, addr_4b = 0, pay_valid = 0;
  logic cmd_pop = 0, addr_pop = 0;
  logic [7:0] cmd_opcode = 0, pay_byte = 0, pay_rd_idx = 0;
  logic [31:0] addr_in = 0;
  logic [7:0] cmd_head, pay_rd_data, pay_start;
  logic [31:0] addr_head;
  logic [3:0] cmd_count, addr_count;
  logic [8:0] pay_occ;
  logic cmd_unavail, cmd_ovf, addr_unavail, addr_ovf;

  upload_capture u0 (.*);

  int checks = 0, fails = 0;
  logic done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {upload, opcode, has_addr, four_b, addr, npay}
  typedef struct packed {
    logic up; logic [7:0] op; logic ha; logic fb; logic [31:0] ad; logic [7:0] np;
  } vec_t;
  localparam vec_t VT [6] = '{
    '{1'b1, 8'h02, 1'b1, 1'b0, 32'hAB123456, 8'd5},
    '{1'b0, 8'h03, 1'b1, 1'b1, 32'h11111111, 8'd7},
    '{1'b1, 8'h06, 1'b0, 1'b0, 32'h0,        8'd0},
    '{1'b1, 8'h32, 1'b1, 1'b1, 32'hCD00FF10, 8'd3},
    '{1'b0, 8'h9F, 1'b0, 1'b0, 32'h0,        8'd4},
    '{1'b1, 8'h20, 1'b1, 1'b0, 32'hFF000040, 8'd0}
  };

  function automatic logic [7:0] pat(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic send(input vec_t v, input int n);
    @(negedge clk);
    cmd_valid = 1; cmd_upload = v.up; cmd_opcode = v.op; addr_4b = v.fb;
    @(negedge clk);
    cmd_valid = 0; cmd_upload = 0;
    if (v.ha) begin
      addr_valid = 1; addr_in = v.ad;
      @(negedge clk);
      addr_valid = 0;
    end
    for (int i = 0; i < n; i++) begin
      pay_valid = 1; pay_byte = pat(i);
      @(negedge clk);
    end
    pay_valid = 0;
  endtask

  initial begin
    logic [7:0]  mop [16];
    logic [31:0] mad [16];
    int nop, nad, occ;
    nop = 0; nad = 0; occ = 0;
    #35 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_count", cmd_count, 0);
    chk("R1 addr_count", addr_count, 0);
    chk("R1 pay_occ", pay_occ, 0);
    chk("R1 pay_start", pay_start, 0);
    chk("R1 ovf", {cmd_ovf, addr_ovf}, 0);

    // Table walk: R2 R4 R5 R7
    for (int k = 0; k < 6; k++) begin
      send(VT[k], int'(VT[k].np));
      if (VT[k].up) begin
        mop[nop] = VT[k].op; nop++;
        if (VT[k].ha) begin
          mad[nad] = VT[k].fb ? VT[k].ad : {8'h00, VT[k].ad[23:0]}; nad++;
        end
        occ = int'(VT[k].np);
      end
      chk("R2 cmd_count", cmd_count, nop);
      chk("R2 addr_count", addr_count, nad);
      chk("R7 R5 pay_occ", pay_occ, occ);
    end

    // R5 payload content: last uploaded with payload was VT[3], 3 bytes; but VT[5] reset occ to 0
    send(VT[0], 6);
    mop[nop] = VT[0].op; nop++; mad[nad] = {8'h00, VT[0].ad[23:0]}; nad++;
    chk("R5 pay_occ", pay_occ, 6);
    chk("R5 pay_start", pay_start, 0);
    for (int i = 0; i < 6; i++) begin
      pay_rd_idx = 8'(i); #1;
      chk("R5 pay_rd_data", pay_rd_data, pat(i));
    end

    // R3 R4 pop in order
    for (int i = 0; i < nop; i++) begin
      @(negedge clk); #1;
      chk("R3 cmd_head", cmd_head, mop[i]);
      cmd_pop = 1;
    end
    @(negedge clk); cmd_pop = 0;
    chk("R3 cmd_count after pops", cmd_count, 0);
    for (int i = 0; i < nad; i++) begin
      @(negedge clk); #1;
      chk("R4 addr_head", addr_head, mad[i]);
      addr_pop = 1;
    end
    @(negedge clk); addr_pop = 0;
    chk("R4 addr_count after pops", addr_count, 0);

    // R8 pop empty
    cmd_pop = 1; addr_pop = 1; #1;
    chk("R8 cmd_unavail", cmd_unavail, 1);
    chk("R8 addr_unavail", addr_unavail, 1);
    @(negedge clk); cmd_pop = 0; addr_pop = 0; #1;
    chk("R8 counts stay 0", {cmd_count, addr_count}, 0);
    chk("R8 unavail low", {cmd_unavail, addr_unavail}, 0);

    // R6 wrap with 260 bytes
    send(VT[2], 260);
    chk("R6 pay_occ sat", pay_occ, 256);
    chk("R6 pay_start", pay_start, 4);
    pay_rd_idx = 8'd4; #1;
    chk("R6 oldest byte", pay_rd_data, pat(4));
    pay_rd_idx = 8'd0; #1;
    chk("R6 overwritten byte", pay_rd_data, pat(256));
    // R7 new uploaded command clears
    send(VT[2], 0);
    chk("R7 pay_occ cleared", pay_occ, 0);
    chk("R7 pay_start cleared", pay_start, 0);

    // R9 overflow: queue holds 2 (VT[2] twice); push 7 more
    for (int i = 0; i < 7; i++) send(VT[3], 0);
    chk("R9 cmd_count full", cmd_count, 8);
    chk("R9 cmd_ovf", cmd_ovf, 1);
    chk("R9 addr_count", addr_count, 7);
    chk("R9 addr_ovf clear", addr_ovf, 0);
    // R10 push and pop in same cycle on non-full: pop one first
    @(negedge clk); cmd_pop = 1; @(negedge clk); cmd_pop = 0;
    chk("R10 count 7", cmd_count, 7);
    @(negedge clk);
    cmd_valid = 1; cmd_upload = 1; cmd_opcode = 8'h77; cmd_pop = 1;
    @(negedge clk);
    cmd_valid = 0; cmd_upload = 0; cmd_pop = 0;
    chk("R10 count unchanged", cmd_count, 7);
    chk("R9 cmd_ovf sticky", cmd_ovf, 1);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule